// File: doc/BRIEF.md
# Priority-Forwarding Request Queue

This block is an in-order request queue placed in front of a shared bus link. Each request carries a 32-bit tag and a priority class: real-time for traffic that must not be starved, such as camera and display streams, and bulk for best-effort traffic, such as mass-storage transfers. Requests always leave in the order they arrived. This causes head-of-queue blocking: a real-time request can sit behind a run of bulk requests.

To clear the blockage, the queue forwards urgency toward the head. Each clock, an entry whose effective priority is real-time raises the entry directly ahead of it. The head's effective priority is shown on the dequeue port, so a downstream arbiter can serve the head early even though it was issued as bulk.

The queue also drives a panic indication for the far side of the link. A one-cycle enter event and a level go out when real-time requests are stored. A one-cycle exit event goes out when the last of them leaves.

Top module: `prio_fwd_queue`

## Requirements
- R1: Entries leave on the dequeue port in exactly the order they were accepted, and the tag is unchanged.
- R2: When all DEPTH slots are occupied and deq_ready_i is low, enq_ready_o is low and no request is taken.
- R3: When all slots are occupied and deq_ready_i is high, enq_ready_o is high. The head leaves and the new request is stored in the same cycle.
- R4: Take a stored entry whose effective priority is real-time (1). The entry one position ahead of it becomes real-time on the next clock. A real-time request stored behind N bulk requests makes the head real-time exactly N clocks after it is stored, if nothing is dequeued.
- R5: deq_rt_o shows the head's effective priority (1 = real-time, 0 = bulk). A request enqueued with enq_rt_i = 1 is real-time from the cycle it is stored.
- R6: An entry's effective priority never falls while the entry stays in the queue.
- R7: panic_enter_o pulses for one cycle in the first cycle that any stored entry was enqueued as real-time. panic_o is high in every cycle in which such an entry is stored.
- R8: panic_exit_o pulses for one cycle in the first cycle after the last entry enqueued as real-time has left.
- R9: Enter and exit events strictly alternate. Two events of the same polarity never follow each other.
- R10: Reset empties the queue and clears the panic level. It raises no exit event.
- R11: While the head is valid and not taken, it stays valid and its tag stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid_i | input | 1 | Request offered |
| enq_ready_o | output | 1 | Request can be taken this cycle |
| enq_rt_i | input | 1 | Request class, 1 = real-time |
| enq_tag_i | input | TAG_W | Request tag |
| deq_valid_o | output | 1 | Head entry present |
| deq_ready_i | input | 1 | Downstream takes the head |
| deq_tag_o | output | TAG_W | Head tag |
| deq_rt_o | output | 1 | Head effective priority, 1 = real-time |
| panic_o | output | 1 | Panic level |
| panic_enter_o | output | 1 | One-cycle panic enter event |
| panic_exit_o | output | 1 | One-cycle panic exit event |

## Verification
The checker watches several rules on every cycle:
- flow control when the queue is full;
- one-step promotion from slot 1 to the head;
- the head's tag and priority holding while it is stalled;
- enter and exit events matching the panic level and alternating;
- the empty, quiet state after reset.

Some properties span many cycles and can only be shown by the bench's scenarios:
- order preserved across a full queue with simultaneous enqueue and dequeue;
- exact N-clock forwarding latency behind N bulk entries;
- no exit event while a second real-time entry remains.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic {
    PRIO_BULK = 1'b0,
    PRIO_RT   = 1'b1
  } prio_e;

  localparam int unsigned DEF_DEPTH = 8;
  localparam int unsigned DEF_TAG_W = 32;
endpackage

// File: rtl/pfq_tag_ram.sv
module pfq_tag_ram #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             rd_adv_i,
  output logic [TAG_W-1:0] rd_tag_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_ptr] <= wr_tag_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en_i)  wr_ptr <= bump(wr_ptr);
      if (rd_adv_i) rd_ptr <= bump(rd_ptr);
    end
  end

  assign rd_tag_o = mem[rd_ptr];
endmodule

// File: rtl/pfq_prio_chain.sv
module pfq_prio_chain #(
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic             push_rt_i,
  input  logic             pop_i,
  output logic [DEPTH-1:0] vld_o,
  output logic [DEPTH-1:0] eff_o,
  output logic [DEPTH-1:0] orig_o
);
  import pfq_pkg::*;

  logic [DEPTH-1:0] vld_q, eff_q, orig_q;
  logic [DEPTH-1:0] sh_vld, sh_eff, sh_orig;
  logic [DEPTH-1:0] take, nxt_vld, nxt_eff, nxt_orig;
  logic             push_is_rt;

  assign push_is_rt = (push_rt_i == PRIO_RT);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic ahead_vld;
    logic behind_eff;

    // Slot contents after an optional shift toward the head
    if (i == DEPTH - 1) begin : g_tail
      assign sh_vld[i]  = pop_i ? 1'b0 : vld_q[i];
      assign sh_eff[i]  = pop_i ? 1'b0 : eff_q[i];
      assign sh_orig[i] = pop_i ? 1'b0 : orig_q[i];
      assign behind_eff = 1'b0;
    end else begin : g_body
      assign sh_vld[i]  = pop_i ? vld_q[i+1]  : vld_q[i];
      assign sh_eff[i]  = pop_i ? eff_q[i+1]  : eff_q[i];
      assign sh_orig[i] = pop_i ? orig_q[i+1] : orig_q[i];
      assign behind_eff = sh_eff[i+1];
    end

    if (i == 0) begin : g_head
      assign ahead_vld = 1'b1;
    end else begin : g_rest
      assign ahead_vld = sh_vld[i-1];
    end

    // New entry lands in the first free slot after the shift
    assign take[i]     = push_i & ~sh_vld[i] & ahead_vld;
    assign nxt_vld[i]  = sh_vld[i] | take[i];
    assign nxt_eff[i]  = take[i] ? push_is_rt
                                 : (sh_vld[i] & (sh_eff[i] | behind_eff));
    assign nxt_orig[i] = take[i] ? push_is_rt : (sh_vld[i] & sh_orig[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      eff_q  <= '0;
      orig_q <= '0;
    end else begin
      vld_q  <= nxt_vld;
      eff_q  <= nxt_eff;
      orig_q <= nxt_orig;
    end
  end

  assign vld_o  = vld_q;
  assign eff_o  = eff_q;
  assign orig_o = orig_q;
endmodule

// File: rtl/pfq_panic_ctrl.sv
module pfq_panic_ctrl #(
  parameter int unsigned DEPTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc_i,
  input  logic dec_i,
  output logic panic_o,
  output logic enter_o,
  output logic exit_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             busy_now, busy_nxt;

  always_comb begin
    unique case ({inc_i, dec_i})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  assign busy_now = (cnt_q != '0);
  assign busy_nxt = (cnt_nxt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      enter_o <= 1'b0;
      exit_o  <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      enter_o <= busy_nxt & ~busy_now;
      exit_o  <= ~busy_nxt & busy_now;
    end
  end

  assign panic_o = busy_now;
endmodule

// File: rtl/prio_fwd_queue.sv
module prio_fwd_queue #(
  parameter int unsigned DEPTH = pfq_pkg::DEF_DEPTH,
  parameter int unsigned TAG_W = pfq_pkg::DEF_TAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid_i,
  output logic             enq_ready_o,
  input  logic             enq_rt_i,
  input  logic [TAG_W-1:0] enq_tag_i,
  output logic             deq_valid_o,
  input  logic             deq_ready_i,
  output logic [TAG_W-1:0] deq_tag_o,
  output logic             deq_rt_o,
  output logic             panic_o,
  output logic             panic_enter_o,
  output logic             panic_exit_o
);
  logic [DEPTH-1:0] vld, eff, orig;
  logic             push, pop;

  assign deq_valid_o = vld[0];
  assign deq_rt_o    = eff[0];
  assign enq_ready_o = ~vld[DEPTH-1] | deq_ready_i;
  assign push        = enq_valid_i & enq_ready_o;
  assign pop         = deq_valid_o & deq_ready_i;

  pfq_tag_ram #(.DEPTH(DEPTH), .TAG_W(TAG_W)) ram_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (push),
    .wr_tag_i (enq_tag_i),
    .rd_adv_i (pop),
    .rd_tag_o (deq_tag_o)
  );

  pfq_prio_chain #(.DEPTH(DEPTH)) chain_i (
    .clk       (clk),
    .rst       (rst),
    .push_i    (push),
    .push_rt_i (enq_rt_i),
    .pop_i     (pop),
    .vld_o     (vld),
    .eff_o     (eff),
    .orig_o    (orig)
  );

  pfq_panic_ctrl #(.DEPTH(DEPTH)) panic_i (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (push & enq_rt_i),
    .dec_i   (pop & orig[0]),
    .panic_o (panic_o),
    .enter_o (panic_enter_o),
    .exit_o  (panic_exit_o)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TAG_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             enq_ready_o,
  input logic             deq_valid_o,
  input logic             deq_ready_i,
  input logic [TAG_W-1:0] deq_tag_o,
  input logic             deq_rt_o,
  input logic             panic_o,
  input logic             panic_enter_o,
  input logic             panic_exit_o,
  input logic [DEPTH-1:0] vld,
  input logic [DEPTH-1:0] eff
);
  logic last_enter;

  always_ff @(posedge clk) begin
    if (rst)                last_enter <= 1'b0;
    else if (panic_enter_o) last_enter <= 1'b1;
    else if (panic_exit_o)  last_enter <= 1'b0;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    vld[DEPTH-1] && !deq_ready_i |-> !enq_ready_o);

  // R3
  full_pass_chk: assert property (@(posedge clk) disable iff (rst)
    vld[DEPTH-1] && deq_ready_i |-> enq_ready_o);

  // R4
  promote_step_chk: assert property (@(posedge clk) disable iff (rst)
    vld[1] && eff[1] && !deq_ready_i |=> deq_rt_o);

  // R6
  prio_keep_chk: assert property (@(posedge clk) disable iff (rst)
    deq_valid_o && deq_rt_o && !deq_ready_i |=> deq_rt_o);

  // R11
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    deq_valid_o && !deq_ready_i |=> deq_valid_o && $stable(deq_tag_o));

  // R7
  enter_level_chk: assert property (@(posedge clk) disable iff (rst)
    panic_enter_o |-> panic_o && !panic_exit_o);

  // R8
  exit_level_chk: assert property (@(posedge clk) disable iff (rst)
    panic_exit_o |-> !panic_o);

  // R9
  alternate_enter_chk: assert property (@(posedge clk) disable iff (rst)
    panic_enter_o |-> !last_enter);

  // R9
  alternate_exit_chk: assert property (@(posedge clk) disable iff (rst)
    panic_exit_o |-> last_enter);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !deq_valid_o && !panic_o && !panic_exit_o);
endmodule

bind prio_fwd_queue pfq_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .enq_ready_o   (enq_ready_o),
  .deq_valid_o   (deq_valid_o),
  .deq_ready_i   (deq_ready_i),
  .deq_tag_o     (deq_tag_o),
  .deq_rt_o      (deq_rt_o),
  .panic_o       (panic_o),
  .panic_enter_o (panic_enter_o),
  .panic_exit_o  (panic_exit_o),
  .vld           (vld),
  .eff           (eff)
);

// File: tb/prio_fwd_queue_tb_top.sv
module prio_fwd_queue_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned TAG_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enq_valid = 1'b0, enq_rt = 1'b0, deq_ready = 1'b0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic             enq_ready, deq_valid, deq_rt, panic, p_enter, p_exit;
  logic [TAG_W-1:0] deq_tag;

  int unsigned n_chk = 0, n_fail = 0;
  bit          done = 1'b0;
  logic [TAG_W-1:0] model_q[$];

  always #2 clk = ~clk;

  prio_fwd_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst),
    .enq_valid_i(enq_valid), .enq_ready_o(enq_ready), .enq_rt_i(enq_rt), .enq_tag_i(enq_tag),
    .deq_valid_o(deq_valid), .deq_ready_i(deq_ready), .deq_tag_o(deq_tag), .deq_rt_o(deq_rt),
    .panic_o(panic), .panic_enter_o(p_enter), .panic_exit_o(p_exit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic rt, input logic [TAG_W-1:0] tag);
    @(negedge clk);
    enq_valid = 1'b1; enq_rt = rt; enq_tag = tag;
    @(posedge clk); #1;
    enq_valid = 1'b0;
    model_q.push_back(tag);
  endtask

  task automatic pop_expect(input logic exp_rt);
    logic [TAG_W-1:0] exp_tag;
    exp_tag = model_q.pop_front();
    @(negedge clk);
    deq_ready = 1'b1;
    check(deq_valid, "R1 valid", 32'(deq_valid), 32'd1);
    check(deq_tag == exp_tag, "R1 order", deq_tag, exp_tag);
    check(deq_rt == exp_rt, "R5 head prio", 32'(deq_rt), 32'(exp_rt));
    @(posedge clk); #1;
    deq_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(!p_exit, "R10 no exit in reset", 32'(p_exit), 32'd0);
    end
    rst = 1'b0;
    model_q.delete();
  endtask

  // R4 / R7 / R8: real-time behind n bulk entries
  task automatic t_forward(input int n);
    for (int i = 0; i < n; i++) push(1'b0, 32'h100 + 32'(i));
    push(1'b1, 32'h1F0);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      check(deq_rt == (k >= n), "R4 forward latency", 32'(deq_rt), 32'(k >= n));
      if (k == 0) check(p_enter, "R7 enter pulse", 32'(p_enter), 32'd1);
      if (k == 1) check(!p_enter, "R7 enter one cycle", 32'(p_enter), 32'd0);
      check(panic, "R7 panic level", 32'(panic), 32'd1);
    end
    for (int i = 0; i <= n; i++) pop_expect(1'b1);
    @(negedge clk);
    check(p_exit, "R8 exit pulse", 32'(p_exit), 32'd1);
    check(!deq_valid, "R1 empty after drain", 32'(deq_valid), 32'd0);
    @(negedge clk);
    check(!p_exit, "R8 exit one cycle", 32'(p_exit), 32'd0);
  endtask

  // R2 / R3: full queue back-pressure and pass-through
  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(1'b0, 32'h50 + 32'(i));
    @(negedge clk);
    check(!enq_ready, "R2 stall when full", 32'(enq_ready), 32'd0);
    enq_valid = 1'b1; enq_rt = 1'b0; enq_tag = 32'h200; deq_ready = 1'b1;
    #0;
    check(enq_ready, "R3 accept on full with dequeue", 32'(enq_ready), 32'd1);
    check(deq_tag == 32'h50, "R3 head leaves", deq_tag, 32'h50);
    @(posedge clk); #1;
    enq_valid = 1'b0; deq_ready = 1'b0;
    void'(model_q.pop_front());
    model_q.push_back(32'h200);
    @(negedge clk);
    check(!enq_ready, "R3 still full", 32'(enq_ready), 32'd0);
    for (int i = 0; i < DEPTH; i++) pop_expect(1'b0);
    @(negedge clk);
    check(!deq_valid, "R1 empty", 32'(deq_valid), 32'd0);
    check(!p_enter && !panic, "R7 bulk raises no panic", 32'(panic), 32'd0);
  endtask

  // R6 / R11: stalled real-time head keeps priority and tag
  task automatic t_stall();
    push(1'b1, 32'h77);
    repeat (3) begin
      @(negedge clk);
      check(deq_rt, "R6 prio held", 32'(deq_rt), 32'd1);
      check(deq_tag == 32'h77, "R11 tag held", deq_tag, 32'h77);
    end
    pop_expect(1'b1);
  endtask

  // R9: two real-time entries give one enter and one exit
  task automatic t_alternate();
    push(1'b1, 32'hA1);
    push(1'b1, 32'hA2);
    @(negedge clk);
    check(!p_enter, "R9 no second enter", 32'(p_enter), 32'd0);
    pop_expect(1'b1);
    @(negedge clk);
    check(!p_exit && panic, "R9 no early exit", 32'(p_exit), 32'd0);
    pop_expect(1'b1);
    @(negedge clk);
    check(p_exit, "R8 exit after last", 32'(p_exit), 32'd1);
  endtask

  // R10: reset while real-time traffic is queued
  task automatic t_reset();
    push(1'b1, 32'hEE);
    push(1'b0, 32'hEF);
    do_reset();
    @(negedge clk);
    check(!deq_valid, "R10 queue empty", 32'(deq_valid), 32'd0);
    check(!panic, "R10 panic cleared", 32'(panic), 32'd0);
    check(!p_exit, "R10 no exit event", 32'(p_exit), 32'd0);
    check(enq_ready, "R10 ready after reset", 32'(enq_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!deq_valid && !panic && !p_enter && !p_exit, "R10 reset state", 32'(deq_valid), 32'd0);
    t_forward(5);
    t_forward(DEPTH - 1);
    t_full();
    t_stall();
    t_alternate();
    t_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule